// File: doc/BRIEF.md
# Serial Two-of-Three Ones Detector

This block takes in one bit per clock on a serial line. In the same cycle, it raises a flag when the current bit and the two bits before it hold exactly two ones. The result is a Mealy output. It depends on the registered history and on the bit now on the line, so a match is reported in the cycle the deciding bit arrives, not one cycle later.

The history is kept as seven explicit states. Three of them cover start-up: nothing seen, one zero seen, and one one seen. The other four record the last two bits. Because of the start-up states, no match can be reported until a full window of three bits exists. A synchronous reset returns the machine to its empty state and holds the flag low while it is applied. An illegal state code falls back to the empty state on the next edge.

Top module: `two_of_three_det`

## Requirements
- R1: In the cycle right after reset is released, and in the cycle after that, `match` stays 0 whatever `din` is, because fewer than three bits have been seen.
- R2: Once at least two bits have been taken since reset, `match` is 1 exactly when the two previously taken bits plus the current `din` contain two ones. It is 0 otherwise.
- R3: A window of three ones (previous two bits 1 and `din` 1) gives `match` 0.
- R4: Starting from reset, the serial input 0,1,1,0,1,1,1,0,0 (first bit first) produces `match` 0,0,1,1,1,1,0,1,0 cycle by cycle.
- R5: `match` follows `din` within a cycle, with no clock edge needed. With the two previous bits 0 then 1, `match` is 1 while `din` is 1 and becomes 0 when `din` changes to 0 in the same cycle.
- R6: While `rst` is 1, `match` is 0, even when the history and `din` would otherwise match. The bit present during a reset cycle is discarded, and the next window starts empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one serial bit is taken on each rising edge |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial data bit |
| match | output | 1 | High when exactly two of the last three bits, counting `din`, are 1 |

## Verification
The reset and a matching window can occur in the same cycle. The bench provokes this by asserting `rst` on the bit that would complete a window of 0,1,1. It expects `match` to be 0 in that cycle, and expects the following bits to be treated as a fresh start with no match for two cycles. A scoreboard model with a two-bit history and a valid-bit count predicts every cycle of long random streams. Those streams include random resets, so this collision also recurs in the random run.

// File: rtl/two_of_three_det.sv
module two_of_three_det (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic match
);

  typedef enum logic [2:0] {
    ST_NONE = 3'b000,
    ST_Z    = 3'b001,
    ST_O    = 3'b010,
    ST_ZZ   = 3'b011,
    ST_ZO   = 3'b100,
    ST_OZ   = 3'b101,
    ST_OO   = 3'b110
  } state_t;

  state_t st, nxt;

  always_comb begin
    case (st)
      ST_NONE: nxt = din ? ST_O  : ST_Z;
      ST_Z:    nxt = din ? ST_ZO : ST_ZZ;
      ST_O:    nxt = din ? ST_OO : ST_OZ;
      ST_ZZ:   nxt = din ? ST_ZO : ST_ZZ;
      ST_ZO:   nxt = din ? ST_OO : ST_OZ;
      ST_OZ:   nxt = din ? ST_ZO : ST_ZZ;
      ST_OO:   nxt = din ? ST_OO : ST_OZ;
      default: nxt = ST_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_NONE;
    else     st <= nxt;
  end

  logic one_prev, two_prev;
  assign one_prev = (st == ST_ZO) || (st == ST_OZ);
  assign two_prev = (st == ST_OO);
  assign match = !rst && ((one_prev && din) || (two_prev && !din));

endmodule

module two_of_three_det_chk (
  input logic       clk,
  input logic       rst,
  input logic       din,
  input logic       match,
  input logic [2:0] st
);

  logic [1:0] hist;
  logic [1:0] seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= 2'b00;
      seen <= 2'd0;
    end else begin
      hist <= {hist[0], din};
      if (seen != 2'd2) seen <= seen + 2'd1;
    end
  end

  // R1
  first_bit_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !match);

  // R1
  second_bit_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst, 2) |-> !match);

  // R2
  window_chk: assert property (@(posedge clk) disable iff (rst)
    (seen == 2'd2) |-> (match == (({1'b0, hist[1]} + {1'b0, hist[0]} + {1'b0, din}) == 2'd2)));

  // R3
  triple_chk: assert property (@(posedge clk) disable iff (rst)
    (seen == 2'd2 && hist == 2'b11 && din) |-> !match);

  // R6
  rst_quiet_chk: assert property (@(posedge clk)
    rst |-> !match);

  // R2
  legal_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (st != 3'b111));

endmodule

bind two_of_three_det two_of_three_det_chk u_chk (
  .clk(clk), .rst(rst), .din(din), .match(match), .st(st)
);

// File: tb/two_of_three_det_test.sv
module two_of_three_det_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic match;

  int n_run = 0;
  int n_fail = 0;
  int cycles = 0;
  bit finished = 0;

  bit    q_exp[$];
  string q_tag[$];

  logic [1:0] m_hist = 2'b00;
  int         m_seen = 0;

  two_of_three_det uut (.clk(clk), .rst(rst), .din(din), .match(match));

  always #2.5 clk = ~clk;

  task automatic chk(input logic got, input logic exp, input string tag);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: match=%b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic drive_bit(input logic b, input logic r, input string force_tag);
    bit    e;
    string t;
    int    ones;
    @(negedge clk);
    din = b;
    rst = r;
    ones = int'(m_hist[1]) + int'(m_hist[0]) + int'(b);
    if (r) begin
      e = 1'b0; t = "R6";
      m_hist = 2'b00; m_seen = 0;
    end else begin
      e = (m_seen >= 2) && (ones == 2);
      if (m_seen < 2)                        t = "R1";
      else if (ones == 3)                    t = "R3";
      else                                   t = "R2";
      m_hist = {m_hist[0], b};
      if (m_seen < 2) m_seen++;
    end
    if (force_tag != "") t = force_tag;
    q_exp.push_back(e);
    q_tag.push_back(t);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (q_exp.size() != 0) chk(match, q_exp.pop_front(), q_tag.pop_front());
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !finished) begin
        n_run++;
        n_fail++;
        $display("FAIL watchdog: run=%0d expected end before 100000 cycles", cycles);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [8:0] seq_in;
    logic [8:0] seq_out;
    seq_in  = 9'b011011100;
    seq_out = 9'b001111010;

    drive_bit(1'b1, 1'b1, "R6");
    drive_bit(1'b0, 1'b1, "R6");

    // R1: no match on first two bits, whatever they are
    drive_bit(1'b1, 1'b0, "R1");
    drive_bit(1'b1, 1'b0, "R1");
    drive_bit(1'b0, 1'b0, "");

    // R4: fixed stream from reset
    drive_bit(1'b0, 1'b1, "R6");
    for (int i = 8; i >= 0; i--) begin
      drive_bit(seq_in[i], 1'b0, "R4");
      if (q_exp[q_exp.size()-1] != seq_out[i]) begin
        n_run++; n_fail++;
        $display("FAIL R4: model=%b expected %b", q_exp[q_exp.size()-1], seq_out[i]);
      end
    end

    // R3: all ones
    drive_bit(1'b1, 1'b0, "R3");
    drive_bit(1'b1, 1'b0, "R3");

    // R6: reset collides with a matching window
    drive_bit(1'b0, 1'b0, "");
    drive_bit(1'b1, 1'b0, "");
    drive_bit(1'b1, 1'b1, "R6");
    drive_bit(1'b1, 1'b0, "R6");
    drive_bit(1'b0, 1'b0, "R6");
    drive_bit(1'b1, 1'b0, "");

    // R5: output follows din inside one cycle
    drive_bit(1'b0, 1'b1, "R6");
    drive_bit(1'b0, 1'b0, "");
    drive_bit(1'b1, 1'b0, "");
    @(negedge clk);
    rst = 1'b0;
    din = 1'b1;
    #1 chk(match, 1'b1, "R5");
    din = 1'b0;
    #1 chk(match, 1'b0, "R5");
    drive_bit(1'b0, 1'b1, "R6");

    // R2: long random streams with occasional reset
    for (int i = 0; i < 4000; i++) begin
      logic r;
      r = ($urandom % 60) == 0;
      drive_bit(1'($urandom), r, "");
    end

    @(negedge clk);
    #2;
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule